// File: doc/BRIEF.md
# SPI Flash Page-Program Sequencer

This block sits on the master side of a single-lane SPI link and writes a byte buffer of any length into a serial NOR flash. A request gives a 24-bit start offset and a byte count. The payload bytes arrive on a valid/ready byte stream. The sequencer cuts the buffer into chunks so that no chunk runs past the end of a flash page. Each chunk is also kept within the controller's transfer limit, which counts the four header bytes.

Each chunk is handled the same way. A one-byte write-enable frame (0x06) goes out first. A program frame follows: opcode 0x02, three address bytes most significant first, then the chunk's data. The sequencer then sends read-status frames (0x05 plus one read byte) until bit 0 of the status byte reads 0. Chip select goes high between any two frames. If the device is still busy after a cycle budget, the transfer is abandoned and an error pulse is raised. A normal finish gives a done pulse.

States:
- `ST_IDLE` waits for a request. A zero count goes to `ST_FINISH`; any other count goes to `ST_CHUNK`.
- `ST_CHUNK` sizes the next chunk and moves to `ST_WREN`.
- `ST_WREN` sends the write-enable byte and then moves to `ST_WREN_GAP`.
- `ST_WREN_GAP` holds chip select high for one cycle and moves to `ST_PROG_HDR`.
- `ST_PROG_HDR` sends the four header bytes and then moves to `ST_PROG_DATA`.
- `ST_PROG_DATA` sends the chunk's data and then moves to `ST_PROG_GAP`.
- `ST_PROG_GAP` clears the timer and moves to `ST_POLL_CMD`.
- `ST_POLL_CMD` sends the read-status opcode and moves to `ST_POLL_READ`.
- `ST_POLL_READ` reads the status byte and moves to `ST_POLL_GAP`.
- `ST_POLL_GAP` decides what comes next:
  - busy, with cycles left in the budget: back to `ST_POLL_CMD`;
  - busy, with the budget used up: to `ST_FAIL`;
  - ready, with bytes still to write: to `ST_CHUNK`;
  - ready, with the buffer finished: to `ST_FINISH`.
- `ST_FINISH` and `ST_FAIL` each last one cycle and return to `ST_IDLE`.

Top module: `spi_pp_seq`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0, done, error and wr_ready are 0.
- R2: Each chunk length is the minimum of three values: the bytes still remaining, the page size minus (offset mod page size), and MAX_XFER minus 4.
- R3: Every program frame is immediately preceded by a frame holding only the byte 0x06.
- R4: A program frame is 0x02, then offset bits 23:16, 15:8 and 7:0, then the chunk's bytes in stream order. Each chunk's offset follows on from the end of the previous chunk. wr_ready is only high while chip select is low.
- R5: After each program frame, frames of 0x05 plus one read byte are repeated until bit 0 of the read byte (the last bit shifted in) is 0. No write-enable or program frame is sent during this polling, and chip select goes high between frames.
- R6: If bit 0 is still 1 once TIMEOUT_CYC cycles have passed since the program frame ended, error pulses for one cycle. No later chunk is written and the block returns to idle.
- R7: A request with length 0 produces a done pulse and no SPI frame.
- R8: SPI mode 0 is used. spi_sclk is low whenever chip select is high, bytes go out most significant bit first, and spi_mosi does not change while spi_sclk is high.
- R9: While wr_valid is low the bus waits with spi_sclk low. Exactly len bytes are taken from the stream per transfer, none dropped or repeated.
- R10: done pulses for one cycle, after the last chunk reports ready. done and error are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| req_start | input | 1 | start a transfer (taken in idle) |
| req_offset | input | 24 | flash byte offset of the first byte |
| req_len | input | LEN_W | number of bytes to write |
| wr_data | input | 8 | payload byte |
| wr_valid | input | 1 | payload byte present |
| wr_ready | output | 1 | payload byte taken this cycle when valid |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | data to flash |
| spi_miso | input | 1 | data from flash |
| done | output | 1 | one-cycle pulse on normal finish |
| error | output | 1 | one-cycle pulse on polling timeout |

## Verification
The bench builds the block with a 16-byte page, MAX_XFER of 16 and a 300-cycle timeout. With a payload cap of 12 bytes, the page limit and the cap each decide the chunk length at different start offsets. A sweep over all sixteen in-page offsets and a set of lengths therefore reaches every combination of the three limits, as well as address carries across the upper offset bytes. A small flash model holds busy for a varying number of polls or for ever. This makes the timeout and the abandoned later chunks reachable within a few hundred cycles.

// File: rtl/spi_pp_pkg.sv
package spi_pp_pkg;
    localparam int ADDR_W = 24;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_PROG = 8'h02;
    localparam logic [7:0] OP_STAT = 8'h05;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHUNK,
        ST_WREN,
        ST_WREN_GAP,
        ST_PROG_HDR,
        ST_PROG_DATA,
        ST_PROG_GAP,
        ST_POLL_CMD,
        ST_POLL_READ,
        ST_POLL_GAP,
        ST_FINISH,
        ST_FAIL
    } seq_state_e;
endpackage

// File: rtl/spi_pp_shifter.sv
// One SPI mode-0 byte: MSB first, sample on rising edge, shift on falling edge.
module spi_pp_shifter #(
    parameter int SCK_DIV = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic [7:0] rx,
    output logic       done
);
    localparam int DIV_W = (SCK_DIV > 1) ? $clog2(SCK_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCK_DIV - 1);

    logic             active;
    logic             hi;
    logic [DIV_W-1:0] cnt;
    logic [2:0]       bits;
    logic [7:0]       sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            hi     <= 1'b0;
            cnt    <= '0;
            bits   <= '0;
            sh     <= '0;
            rx     <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !active) begin
                active <= 1'b1;
                hi     <= 1'b0;
                cnt    <= '0;
                bits   <= '0;
                sh     <= tx;
            end else if (active) begin
                if (cnt == DIV_LAST) begin
                    cnt <= '0;
                    if (!hi) begin
                        hi <= 1'b1;
                        rx <= {rx[6:0], miso};
                    end else begin
                        hi <= 1'b0;
                        sh <= {sh[6:0], 1'b0};
                        if (bits == 3'd7) begin
                            active <= 1'b0;
                            done   <= 1'b1;
                        end else begin
                            bits <= bits + 3'd1;
                        end
                    end
                end else begin
                    cnt <= cnt + DIV_W'(1);
                end
            end
        end
    end

    assign sclk = hi;
    assign mosi = sh[7];
endmodule

// File: rtl/spi_pp_chunk.sv
// Chunk length = min(remaining, bytes to page end, payload cap).
module spi_pp_chunk #(
    parameter int PAGE_SHIFT = 8,
    parameter int MAX_XFER   = 64,
    parameter int LEN_W      = 16
) (
    input  logic [PAGE_SHIFT-1:0] addr_lo,
    input  logic [LEN_W-1:0]      remaining,
    output logic [PAGE_SHIFT:0]   chunk
);
    localparam int CHUNK_W = PAGE_SHIFT + 1;
    localparam int PAGE    = 1 << PAGE_SHIFT;
    localparam int CAP     = MAX_XFER - 4;
    localparam int CAP_EFF = (CAP < PAGE) ? CAP : PAGE;
    localparam logic [CHUNK_W-1:0] PAGE_V = CHUNK_W'(PAGE);
    localparam logic [CHUNK_W-1:0] CAP_V  = CHUNK_W'(CAP_EFF);

    logic [CHUNK_W-1:0] page_left;
    logic [CHUNK_W-1:0] rem_c;
    logic [CHUNK_W-1:0] lim;

    always_comb begin
        page_left = PAGE_V - {1'b0, addr_lo};
        rem_c     = (remaining >= LEN_W'(PAGE)) ? PAGE_V : remaining[CHUNK_W-1:0];
        lim       = (CAP_V < page_left) ? CAP_V : page_left;
        chunk     = (rem_c < lim) ? rem_c : lim;
    end
endmodule

// File: rtl/spi_pp_seq.sv
module spi_pp_seq
    import spi_pp_pkg::*;
#(
    parameter int PAGE_SHIFT  = 8,
    parameter int MAX_XFER    = 64,
    parameter int LEN_W       = 16,
    parameter int SCK_DIV     = 2,
    parameter int TIMEOUT_CYC = 400000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic [23:0]       req_offset,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [7:0]        wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              done,
    output logic              error
);
    localparam int CHUNK_W = PAGE_SHIFT + 1;
    localparam int TMO_W   = $clog2(TIMEOUT_CYC + 1);
    localparam logic [TMO_W-1:0] TMO_V = TMO_W'(TIMEOUT_CYC);

    seq_state_e state, state_nx;

    logic [ADDR_W-1:0]  cur_addr;
    logic [LEN_W-1:0]   remaining;
    logic [CHUNK_W-1:0] chunk_len;
    logic [CHUNK_W-1:0] chunk_nx;
    logic [CHUNK_W-1:0] idx;
    logic [1:0]         hdr_idx;
    logic               inflight;
    logic [TMO_W-1:0]   tmr;
    logic               st_busy;

    logic       sh_start;
    logic [7:0] sh_tx;
    logic [7:0] sh_rx;
    logic       sh_done;

    spi_pp_shifter #(.SCK_DIV(SCK_DIV)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .start (sh_start),
        .tx    (sh_tx),
        .miso  (spi_miso),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi),
        .rx    (sh_rx),
        .done  (sh_done)
    );

    spi_pp_chunk #(
        .PAGE_SHIFT (PAGE_SHIFT),
        .MAX_XFER   (MAX_XFER),
        .LEN_W      (LEN_W)
    ) u_chunk (
        .addr_lo   (cur_addr[PAGE_SHIFT-1:0]),
        .remaining (remaining),
        .chunk     (chunk_nx)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (req_start) state_nx = (req_len == '0) ? ST_FINISH : ST_CHUNK;
            ST_CHUNK:     state_nx = ST_WREN;
            ST_WREN:      if (sh_done) state_nx = ST_WREN_GAP;
            ST_WREN_GAP:  state_nx = ST_PROG_HDR;
            ST_PROG_HDR:  if (sh_done && hdr_idx == 2'd3) state_nx = ST_PROG_DATA;
            ST_PROG_DATA: if (sh_done && idx == chunk_len - CHUNK_W'(1)) state_nx = ST_PROG_GAP;
            ST_PROG_GAP:  state_nx = ST_POLL_CMD;
            ST_POLL_CMD:  if (sh_done) state_nx = ST_POLL_READ;
            ST_POLL_READ: if (sh_done) state_nx = ST_POLL_GAP;
            ST_POLL_GAP: begin
                if (st_busy)
                    state_nx = (tmr >= TMO_V) ? ST_FAIL : ST_POLL_CMD;
                else
                    state_nx = (remaining == '0) ? ST_FINISH : ST_CHUNK;
            end
            ST_FINISH:    state_nx = ST_IDLE;
            ST_FAIL:      state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            remaining <= '0;
            chunk_len <= '0;
            idx       <= '0;
            hdr_idx   <= '0;
            inflight  <= 1'b0;
            tmr       <= '0;
            st_busy   <= 1'b0;
        end else begin
            if (sh_start)     inflight <= 1'b1;
            else if (sh_done) inflight <= 1'b0;

            unique case (state)
                ST_IDLE: if (req_start) begin
                    cur_addr  <= req_offset;
                    remaining <= req_len;
                end
                ST_CHUNK: begin
                    chunk_len <= chunk_nx;
                    idx       <= '0;
                    hdr_idx   <= '0;
                end
                ST_PROG_HDR: if (sh_done) hdr_idx <= hdr_idx + 2'd1;
                ST_PROG_DATA: if (sh_done) begin
                    idx       <= idx + CHUNK_W'(1);
                    cur_addr  <= cur_addr + ADDR_W'(1);
                    remaining <= remaining - LEN_W'(1);
                end
                ST_PROG_GAP: tmr <= '0;
                ST_POLL_CMD, ST_POLL_READ, ST_POLL_GAP: begin
                    if (tmr != {TMO_W{1'b1}}) tmr <= tmr + TMO_W'(1);
                    if (state == ST_POLL_READ && sh_done) st_busy <= sh_rx[0];
                end
                default: ;
            endcase
        end
    end

    // Outputs and byte selection
    always_comb begin
        spi_cs_n = 1'b1;
        wr_ready = 1'b0;
        sh_start = 1'b0;
        sh_tx    = 8'h00;
        done     = 1'b0;
        error    = 1'b0;
        unique case (state)
            ST_WREN: begin
                spi_cs_n = 1'b0;
                sh_tx    = OP_WREN;
                sh_start = !inflight;
            end
            ST_PROG_HDR: begin
                spi_cs_n = 1'b0;
                sh_start = !inflight;
                unique case (hdr_idx)
                    2'd0: sh_tx = OP_PROG;
                    2'd1: sh_tx = cur_addr[23:16];
                    2'd2: sh_tx = cur_addr[15:8];
                    default: sh_tx = cur_addr[7:0];
                endcase
            end
            ST_PROG_DATA: begin
                spi_cs_n = 1'b0;
                wr_ready = !inflight;
                sh_tx    = wr_data;
                sh_start = !inflight && wr_valid;
            end
            ST_POLL_CMD: begin
                spi_cs_n = 1'b0;
                sh_tx    = OP_STAT;
                sh_start = !inflight;
            end
            ST_POLL_READ: begin
                spi_cs_n = 1'b0;
                sh_start = !inflight;
            end
            ST_FINISH: done  = 1'b1;
            ST_FAIL:   error = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/spi_pp_seq_chk.sv
module spi_pp_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic spi_cs_n,
    input logic spi_sclk,
    input logic spi_mosi,
    input logic wr_ready,
    input logic done,
    input logic error
);
    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk); // R8
    AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi)); // R8
    AST_READY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> !spi_cs_n); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error)); // R10
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> !error); // R6
    AST_END_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |-> spi_cs_n); // R5
endmodule

bind spi_pp_seq spi_pp_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_cs_n (spi_cs_n),
    .spi_sclk (spi_sclk),
    .spi_mosi (spi_mosi),
    .wr_ready (wr_ready),
    .done     (done),
    .error    (error)
);

// File: tb/sim_spi_pp_seq.sv
`timescale 1ns/1ps
module sim_spi_pp_seq;
    localparam int PS  = 4;
    localparam int PG  = 1 << PS;
    localparam int MX  = 16;
    localparam int CAP = MX - 4;
    localparam int LW  = 8;
    localparam int TMO = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_start = 1'b0;
    logic [23:0] req_offset = '0;
    logic [LW-1:0] req_len = '0;
    logic [7:0] wr_data = '0;
    logic wr_valid = 1'b0;
    logic wr_ready, spi_sclk, spi_cs_n, spi_mosi, done, error;
    logic spi_miso;

    always #5 clk = ~clk;

    spi_pp_seq #(.PAGE_SHIFT(PS), .MAX_XFER(MX), .LEN_W(LW), .SCK_DIV(1),
                 .TIMEOUT_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_offset(req_offset),
        .req_len(req_len), .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .done(done), .error(error));

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int k);
        return 8'((k * 37 + 11) & 255);
    endfunction

    // ---------------- flash model ----------------
    logic [7:0] fr [0:63];
    logic [7:0] cur;
    int nb = 0, bc = 0;
    int busy_left = 0, busy_polls = 0;
    bit stuck = 0, stat_busy = 0, wel = 0;
    int n_prog = 0, n_poll = 0, n_frames = 0, n_bad = 0, data_bad = 0, sclk_bad = 0;
    int pa [0:63];
    int pl [0:63];
    bit pw [0:63];
    int kbase = 0;
    int s_off = 0;

    initial spi_miso = 1'b0;

    always @(negedge spi_cs_n) begin
        nb = 0; bc = 0;
        stat_busy = stuck || (busy_left > 0);
        if (spi_sclk) sclk_bad++;
    end

    always @(posedge spi_sclk) if (!spi_cs_n) begin
        cur = {cur[6:0], spi_mosi};
        bc++;
        if (bc == 8) begin
            if (nb < 64) fr[nb] = cur;
            nb++;
            bc = 0;
        end
    end

    always @(negedge spi_sclk) if (!spi_cs_n) begin
        if (nb >= 1 && fr[0] == 8'h05) spi_miso = (bc == 7) ? stat_busy : 1'b0;
        else spi_miso = 1'b0;
    end

    always @(posedge spi_cs_n) if (nb > 0) begin
        if (spi_sclk) sclk_bad++;
        n_frames++;
        if (nb == 1 && fr[0] == 8'h06) wel = 1;
        else if (nb > 4 && fr[0] == 8'h02) begin
            if (n_prog < 64) begin
                pa[n_prog] = {8'h00, fr[1], fr[2], fr[3]};
                pl[n_prog] = nb - 4;
                pw[n_prog] = wel;
            end
            for (int i = 4; i < nb; i++) begin
                int a;
                a = {8'h00, fr[1], fr[2], fr[3]} + i - 4;
                if (fr[i] != pat(kbase + ((a - s_off) & 24'hFFFFFF))) data_bad++;
            end
            n_prog++;
            wel = 0;
            busy_left = busy_polls;
        end else if (nb == 2 && fr[0] == 8'h05) begin
            n_poll++;
            wel = 0;
            if (busy_left > 0) busy_left--;
        end else n_bad++;
    end

    // ---------------- stream driver ----------------
    int k = 0;
    int cyc = 0;
    bit take = 0;
    bit stall_en = 0;
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (take) k++;
            wr_data  = pat(k);
            wr_valid = !(stall_en && (cyc % 5 == 3));
            take     = wr_ready && wr_valid;
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // ---------------- scenario ----------------
    int ea [0:63];
    int el [0:63];
    int en;

    task automatic expect_chunks(input int off, input int len);
        int o, r, c;
        o = off; r = len; en = 0;
        while (r > 0) begin
            c = PG - (o % PG);
            if (CAP < c) c = CAP;
            if (r < c) c = r;
            ea[en] = o & 24'hFFFFFF; el[en] = c; en++;
            o += c; r -= c;
        end
    endtask

    task automatic run(input int off, input int len, output bit got_done,
                       output bit got_err, output int cycles);
        n_prog = 0; n_poll = 0; n_bad = 0; data_bad = 0; n_frames = 0;
        kbase = k; s_off = off;
        @(negedge clk);
        req_offset = 24'(off); req_len = LW'(len); req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        got_done = 0; got_err = 0; cycles = 1;
        while (!done && !error && cycles < 6000) begin
            @(negedge clk);
            cycles++;
        end
        got_done = done; got_err = error;
        @(negedge clk);
    endtask

    function automatic int lenf(input int i);
        case (i)
            0: return 0;  1: return 1;  2: return 2;  3: return 5;
            4: return 12; 5: return 13; 6: return 17; default: return 29;
        endcase
    endfunction

    initial begin
        bit gd, ge;
        int cy;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(spi_cs_n == 1'b1, "R1 cs_n", spi_cs_n, 1);
        chk(spi_sclk == 1'b0, "R1 sclk", spi_sclk, 0);
        chk(done == 1'b0 && error == 1'b0, "R1 done/error", {done, error}, 0);
        chk(wr_ready == 1'b0, "R1 wr_ready", wr_ready, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int o = 0; o < PG; o++) begin
            for (int li = 0; li < 8; li++) begin
                int len, off, k0;
                len = lenf(li);
                off = 24'h01FFE0 + o;
                busy_polls = (o + li) % 3;
                stall_en = (o % 2) == 1;
                k0 = k;
                expect_chunks(off, len);
                run(off, len, gd, ge, cy);
                chk(gd, "R10 done seen", gd, 1);
                chk(!ge, "R6 no error", ge, 0);
                if (len == 0) chk(n_frames == 0, "R7 no frames on zero length", n_frames, 0);
                chk(n_prog == en, "R2 chunk count", n_prog, en);
                for (int c = 0; c < en && c < n_prog; c++) begin
                    chk(pl[c] == el[c], "R2 chunk length", pl[c], el[c]);
                    chk(pa[c] == ea[c], "R4 chunk address", pa[c], ea[c]);
                    chk(pw[c], "R3 write-enable precedes program", pw[c], 1);
                end
                chk(data_bad == 0, "R4 data bytes", data_bad, 0);
                chk(n_poll == en * (busy_polls + 1), "R5 poll frames", n_poll, en * (busy_polls + 1));
                chk(n_bad == 0, "R5 unexpected frames", n_bad, 0);
                chk(k - k0 == len, "R9 bytes consumed", k - k0, len);
            end
        end
        chk(sclk_bad == 0, "R8 sclk low at chip-select edges", sclk_bad, 0);
        chk(spi_sclk == 1'b0 && spi_cs_n == 1'b1, "R8 idle bus", {spi_sclk, spi_cs_n}, 1);

        // R6 timeout: device never becomes ready
        stuck = 1; busy_polls = 0; stall_en = 0;
        run(24'h000003, 20, gd, ge, cy);
        chk(ge, "R6 error raised", ge, 1);
        chk(!gd, "R6 no done on timeout", gd, 0);
        chk(n_prog == 1, "R6 later chunks unwritten", n_prog, 1);
        chk(cy >= TMO, "R6 waits the full budget", cy, TMO);
        stuck = 0; busy_left = 0;
        repeat (3) @(negedge clk);
        chk(spi_cs_n == 1'b1 && !error, "R6 back to idle", spi_cs_n, 1);

        // recovery after an abort
        expect_chunks(24'h00000E, 6);
        run(24'h00000E, 6, gd, ge, cy);
        chk(gd && !ge, "R10 done after recovery", gd, 1);
        chk(n_prog == en, "R2 chunk count after recovery", n_prog, en);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule